// File: doc/BRIEF.md
# Control Endpoint Handshake Register

This block is the eight-bit control and status register of a USB device's endpoint zero. It sits between a processor write/read port and the endpoint's packet engine. It holds the handshake flags for a packet waiting to go out, a packet that has arrived, a control transfer that aborted early, a final data packet, a pending stall request and a stall that has been sent. Software sets and clears the flags through writes. Each flag bit follows its own write rule: write-1-to-set, write-1-to-clear through a separate strobe bit, write-0-to-clear, or read-only.

The packet engine drives single-cycle event strobes into the block: packet transmitted, packet received, control transfer aborted, stall handshake sent and status stage complete. Each strobe sets or clears flags in the next register update. From the same events the block forms a one-cycle interrupt pulse and a one-cycle FIFO flush strobe. It also drives two steady levels that mirror flags back to the engine: a request to send a stall and an indication that the current packet is the last one.

The asynchronous active-low reset is asserted at once and released through a two-stage synchronizer, so the block leaves reset on the second rising clock edge after `rst_n` goes high.

Top module: `ep0_ctl_status`

## Requirements
- R1: While reset is asserted, and after reset until the first write or event, `rd_data` reads 0x00 and `irq`, `fifo_flush`, `stall_req` and `last_pkt` are 0.
- R2: Bits 7 and 6 of `rd_data` always read 0. Writing 1 to bit 0 or to bit 4 never sets those bits.
- R3: Writing 1 to bit 1 sets the transmit-ready flag, and writing 0 to bit 1 leaves it unchanged. A `ev_tx_done` strobe clears it, and if the flag was set the strobe also raises `irq`. A write of 1 to bit 1 in the same cycle as `ev_tx_done` leaves the flag set.
- R4: An `ev_rx_pkt` strobe sets the receive-ready flag (bit 0) and raises `irq`. Writing 1 to bit 6 clears the flag.
- R5: Writing 1 to bit 5 sets the send-stall flag, and `stall_req` follows that flag. An `ev_stall_sent` strobe clears it. Writing 0 to bit 5 has no effect.
- R6: An `ev_stall_sent` strobe sets the stalled flag (bit 2) and raises `irq`. Writing 0 to bit 2 clears the flag, and writing 1 to bit 2 has no effect.
- R7: An `ev_ctl_abort` strobe while the data-end flag is 0 sets the setup-end flag (bit 4) and raises both `irq` and `fifo_flush`. If data-end is 1, the strobe does nothing. Writing 1 to bit 7 clears setup-end.
- R8: Writing 1 to bit 3 sets the data-end flag, and `last_pkt` follows that flag. An `ev_status_done` strobe clears it. Writing 0 to bit 3 has no effect.
- R9: When a hardware event sets a flag and a write clears the same flag in the same cycle, the flag ends up set.
- R10: `irq` and `fifo_flush` are registered. They are high during the cycle that follows the clock edge that sampled their cause. `irq` is the OR of all causes in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Register read value |
| ev_tx_done | input | 1 | Packet transmitted |
| ev_rx_pkt | input | 1 | Packet received |
| ev_ctl_abort | input | 1 | Control transfer ended early |
| ev_stall_sent | input | 1 | Stall handshake sent |
| ev_status_done | input | 1 | Status stage complete |
| irq | output | 1 | Interrupt pulse |
| fifo_flush | output | 1 | FIFO flush strobe |
| stall_req | output | 1 | Send-stall request level |
| last_pkt | output | 1 | Last data packet level |

## Verification
On every cycle, the assertions check the following:
- the strobe bits read as zero;
- a received packet or a sent stall leaves its flag set and the interrupt high one cycle later, even when a write clears the flag in that same cycle;
- every rise of setup-end comes with a flush strobe;
- a stall request write always reaches `stall_req`.

Some behaviour only the bench's scenarios can show:
- the abort strobe is ignored while data-end is set;
- zero writes to write-1 bits have no effect;
- the transmit-ready interrupt appears only when a packet was actually pending;
- the flag state follows a long random mix of writes and events.

// File: rtl/ep0_csr_pkg.sv
package ep0_csr_pkg;
  localparam int CSR_W      = 8;
  localparam int NFLAG      = 6;
  // bit positions decoded by software
  localparam int B_RXRDY    = 0;
  localparam int B_TXRDY    = 1;
  localparam int B_STALLED  = 2;
  localparam int B_DATAEND  = 3;
  localparam int B_SETUPEND = 4;
  localparam int B_SENDSTL  = 5;
  localparam int B_RXCLR    = 6;
  localparam int B_SUCLR    = 7;
endpackage

// File: rtl/ep0_rst_sync.sv
module ep0_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/ep0_wr_decode.sv
module ep0_wr_decode
  import ep0_csr_pkg::*;
(
  input  logic             wr_en,
  input  logic [CSR_W-1:0] wr_data,
  input  logic             ev_tx_done,
  input  logic             ev_rx_pkt,
  input  logic             ev_ctl_abort,
  input  logic             ev_stall_sent,
  input  logic             ev_status_done,
  input  logic [NFLAG-1:0] flag_q,
  output logic [NFLAG-1:0] flag_set,
  output logic [NFLAG-1:0] flag_clr,
  output logic             irq_cause,
  output logic             flush_cause
);
  logic abort_hit;

  always_comb begin
    abort_hit = ev_ctl_abort && !flag_q[B_DATAEND];

    flag_set = '0;
    flag_clr = '0;

    flag_set[B_RXRDY]    = ev_rx_pkt;
    flag_clr[B_RXRDY]    = wr_en && wr_data[B_RXCLR];

    flag_set[B_TXRDY]    = wr_en && wr_data[B_TXRDY];
    flag_clr[B_TXRDY]    = ev_tx_done;

    flag_set[B_STALLED]  = ev_stall_sent;
    flag_clr[B_STALLED]  = wr_en && !wr_data[B_STALLED];

    flag_set[B_DATAEND]  = wr_en && wr_data[B_DATAEND];
    flag_clr[B_DATAEND]  = ev_status_done;

    flag_set[B_SETUPEND] = abort_hit;
    flag_clr[B_SETUPEND] = wr_en && wr_data[B_SUCLR];

    flag_set[B_SENDSTL]  = wr_en && wr_data[B_SENDSTL];
    flag_clr[B_SENDSTL]  = ev_stall_sent;

    irq_cause   = (ev_tx_done && flag_q[B_TXRDY]) || ev_rx_pkt ||
                  abort_hit || ev_stall_sent;
    flush_cause = abort_hit;
  end
endmodule

// File: rtl/ep0_flag.sv
module ep0_flag #(
  parameter bit SET_WINS = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  logic q_en;
  logic q_nxt;

  always_comb begin
    q_en  = set || clr;
    q_nxt = q;
    if (set && clr) q_nxt = SET_WINS;
    else if (set)   q_nxt = 1'b1;
    else if (clr)   q_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= 1'b0;
    else if (q_en) q <= q_nxt;
  end
endmodule

// File: rtl/ep0_evt_out.sv
module ep0_evt_out (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_cause,
  input  logic flush_cause,
  output logic irq,
  output logic fifo_flush
);
  logic irq_nxt;
  logic flush_nxt;

  always_comb begin
    irq_nxt   = irq_cause;
    flush_nxt = flush_cause;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq        <= 1'b0;
      fifo_flush <= 1'b0;
    end else begin
      irq        <= irq_nxt;
      fifo_flush <= flush_nxt;
    end
  end
endmodule

// File: rtl/ep0_ctl_status.sv
module ep0_ctl_status
  import ep0_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CSR_W-1:0] wr_data,
  output logic [CSR_W-1:0] rd_data,
  input  logic             ev_tx_done,
  input  logic             ev_rx_pkt,
  input  logic             ev_ctl_abort,
  input  logic             ev_stall_sent,
  input  logic             ev_status_done,
  output logic             irq,
  output logic             fifo_flush,
  output logic             stall_req,
  output logic             last_pkt
);
  localparam int PAD_W = CSR_W - NFLAG;

  logic             rst_n_s;
  logic [NFLAG-1:0] flag_q;
  logic [NFLAG-1:0] flag_set;
  logic [NFLAG-1:0] flag_clr;
  logic             irq_cause;
  logic             flush_cause;

  ep0_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  ep0_wr_decode u_dec (
    .wr_en          (wr_en),
    .wr_data        (wr_data),
    .ev_tx_done     (ev_tx_done),
    .ev_rx_pkt      (ev_rx_pkt),
    .ev_ctl_abort   (ev_ctl_abort),
    .ev_stall_sent  (ev_stall_sent),
    .ev_status_done (ev_status_done),
    .flag_q         (flag_q),
    .flag_set       (flag_set),
    .flag_clr       (flag_clr),
    .irq_cause      (irq_cause),
    .flush_cause    (flush_cause)
  );

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    ep0_flag #(.SET_WINS(1'b1)) u_flag (
      .clk   (clk),
      .rst_n (rst_n_s),
      .set   (flag_set[i]),
      .clr   (flag_clr[i]),
      .q     (flag_q[i])
    );
  end

  ep0_evt_out u_evt (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .irq_cause   (irq_cause),
    .flush_cause (flush_cause),
    .irq         (irq),
    .fifo_flush  (fifo_flush)
  );

  assign rd_data   = {{PAD_W{1'b0}}, flag_q};
  assign stall_req = flag_q[B_SENDSTL];
  assign last_pkt  = flag_q[B_DATAEND];

  // R2
  strobe_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    rd_data[B_SUCLR:B_RXCLR] == 2'b00);

  // R4
  rx_set_irq_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    ev_rx_pkt |=> (rd_data[B_RXRDY] && irq));

  // R6
  stalled_set_irq_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    ev_stall_sent |=> (rd_data[B_STALLED] && irq));

  // R7
  setup_rise_flush_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(rd_data[B_SETUPEND]) |-> (fifo_flush && irq));

  // R7
  flush_has_setup_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    fifo_flush |-> rd_data[B_SETUPEND]);

  // R5
  stall_write_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_en && wr_data[B_SENDSTL]) |=> stall_req);
endmodule

// File: tb/ep0_ctl_status_test.sv
module ep0_ctl_status_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       ev_tx_done, ev_rx_pkt, ev_ctl_abort, ev_stall_sent, ev_status_done;
  logic       irq, fifo_flush, stall_req, last_pkt;

  int errors = 0;
  int checks = 0;
  logic [5:0] m = '0;   // expected flags
  logic       irq_e = 1'b0;
  logic       fl_e  = 1'b0;

  always #5 clk = ~clk;

  ep0_ctl_status uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .ev_tx_done(ev_tx_done), .ev_rx_pkt(ev_rx_pkt), .ev_ctl_abort(ev_ctl_abort),
    .ev_stall_sent(ev_stall_sent), .ev_status_done(ev_status_done),
    .irq(irq), .fifo_flush(fifo_flush), .stall_req(stall_req), .last_pkt(last_pkt)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ev = {status_done, stall_sent, ctl_abort, rx_pkt, tx_done}
  function automatic logic [7:0] model(input logic [5:0] s, input logic w,
                                       input logic [7:0] d, input logic [4:0] ev);
    logic [5:0] n;
    logic su, iq;
    su = ev[2] && !s[3];
    iq = (ev[0] && s[1]) || ev[1] || su || ev[3];
    n = s;
    if (w && d[6]) n[0] = 1'b0;   // R4
    if (ev[1])     n[0] = 1'b1;
    if (ev[0])     n[1] = 1'b0;   // R3
    if (w && d[1]) n[1] = 1'b1;
    if (w && !d[2]) n[2] = 1'b0;  // R6
    if (ev[3])     n[2] = 1'b1;
    if (ev[4])     n[3] = 1'b0;   // R8
    if (w && d[3]) n[3] = 1'b1;
    if (w && d[7]) n[4] = 1'b0;   // R7
    if (su)        n[4] = 1'b1;
    if (ev[3])     n[5] = 1'b0;   // R5
    if (w && d[5]) n[5] = 1'b1;
    return {su, iq, n};
  endfunction

  task automatic check_all();
    chk("R4 rx_ready",   rd_data[0], m[0]);
    chk("R3 tx_ready",   rd_data[1], m[1]);
    chk("R6 stalled",    rd_data[2], m[2]);
    chk("R8 data_end",   rd_data[3], m[3]);
    chk("R7 setup_end",  rd_data[4], m[4]);
    chk("R5 send_stall", rd_data[5], m[5]);
    chk("R2 strobe_bits", rd_data[7:6], 0);
    chk("R10 irq",       irq, irq_e);
    chk("R7 fifo_flush", fifo_flush, fl_e);
    chk("R5 stall_req",  stall_req, m[5]);
    chk("R8 last_pkt",   last_pkt, m[3]);
  endtask

  task automatic cyc(input logic w, input logic [7:0] d, input logic [4:0] ev);
    logic [7:0] r;
    @(negedge clk);
    wr_en = w; wr_data = d;
    {ev_status_done, ev_stall_sent, ev_ctl_abort, ev_rx_pkt, ev_tx_done} = ev;
    r = model(m, w, d, ev);
    @(posedge clk); #1;
    m = r[5:0]; irq_e = r[6]; fl_e = r[7];
    check_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h0E0C_5A11));
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0;
    {ev_status_done, ev_stall_sent, ev_ctl_abort, ev_rx_pkt, ev_tx_done} = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1 during reset
    chk("R1 reset rd_data", rd_data, 8'h00);
    chk("R1 reset irq", {irq, fifo_flush, stall_req, last_pkt}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 after release", rd_data, 8'h00);
    cyc(1'b0, 8'h00, 5'b00000);

    // R2: bits 0 and 4 not writable
    cyc(1'b1, 8'h11, 5'b00000);
    chk("R2 ro bits", rd_data & 8'h11, 0);
    // R3: set tx, zero write no effect, tx_done clears with irq
    cyc(1'b1, 8'h02, 5'b00000);
    cyc(1'b1, 8'h04, 5'b00000);
    chk("R3 zero write keeps", rd_data[1], 1);
    cyc(1'b0, 8'h00, 5'b00001);
    chk("R3 done irq", irq, 1);
    cyc(1'b0, 8'h00, 5'b00001);
    chk("R3 no irq when idle", irq, 0);
    // R3 CPU set with tx_done same cycle
    cyc(1'b1, 8'h02, 5'b00001);
    chk("R3 set beats done", rd_data[1], 1);
    // R4 rx set then clear
    cyc(1'b0, 8'h00, 5'b00010);
    cyc(1'b1, 8'h40, 5'b00000);
    chk("R4 cleared", rd_data[0], 0);
    // R9 rx set vs clear same cycle
    cyc(1'b1, 8'h40, 5'b00010);
    chk("R9 rx set wins", rd_data[0], 1);
    // R5 and R6 stall
    cyc(1'b1, 8'h24, 5'b00000);
    chk("R6 write1 no effect", rd_data[2], 0);
    cyc(1'b0, 8'h00, 5'b01000);
    chk("R5 stall cleared", stall_req, 0);
    chk("R6 stalled set", rd_data[2], 1);
    // R9 stalled set vs zero write
    cyc(1'b1, 8'h00, 5'b01000);
    chk("R9 stalled set wins", rd_data[2], 1);
    cyc(1'b1, 8'h00, 5'b00000);
    chk("R6 write0 clears", rd_data[2], 0);
    // R7 abort with data_end set is ignored
    cyc(1'b1, 8'h08, 5'b00000);
    cyc(1'b0, 8'h00, 5'b00100);
    chk("R7 ignored flush", fifo_flush, 0);
    chk("R7 ignored setup", rd_data[4], 0);
    cyc(1'b0, 8'h00, 5'b10000);
    chk("R8 status clears", last_pkt, 0);
    // R7 abort sets setup_end, R9 vs clear strobe
    cyc(1'b1, 8'h80, 5'b00100);
    chk("R9 setup set wins", rd_data[4], 1);
    chk("R7 flush", fifo_flush, 1);
    cyc(1'b0, 8'h00, 5'b00000);
    chk("R10 single pulse", {irq, fifo_flush}, 0);
    cyc(1'b1, 8'h80, 5'b00000);
    chk("R7 clear strobe", rd_data[4], 0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic w; logic [7:0] d; logic [4:0] ev;
      w = ($urandom % 4) == 0;
      d = 8'($urandom);
      for (int k = 0; k < 5; k++) ev[k] = ($urandom % 6) == 0;
      cyc(w, d, ev);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule